// File: doc/BRIEF.md
# Interrupt Target CPU Selector

This block chooses the processor that a newly registered interrupt is delivered to. A request carries the online-processor bitmask, an optional node-local processor bitmask with its valid bit, the interrupt vector number, a redirection-enable flag and the index of the requesting processor. After a bounded number of cycles the block raises `done` for one cycle. At that point `target` holds the chosen processor index.

The choice runs through a fixed order. If redirection is enabled, or the requester is offline, the requester is chosen at once. When no processor is online at all, the requester is chosen and `err` is raised. Otherwise, when the node mask is valid and some node processors are online, the block computes the vector modulo the number of online node processors with a restoring shift-subtract unit. It then walks the online node processors upward from index 0 until it reaches that position. In every other case a persistent round-robin pointer advances over the processors, wrapping at the processor count, until it lands on an online one. The pointer begins in a "before CPU 0" state after reset.

The controller is a five-state machine:

- `ST_IDLE` waits for `req`. It moves to `ST_FIN` (fast path), `ST_DIVIDE` (node path) or `ST_ROUND` (round-robin).
- `ST_DIVIDE` waits for the remainder and then moves to `ST_NODE_SCAN`.
- `ST_NODE_SCAN` checks one processor per cycle and moves to `ST_FIN` on the selected one.
- `ST_ROUND` advances the pointer one processor per cycle and moves to `ST_FIN` on an online processor.
- `ST_FIN` drives `done` and returns to `ST_IDLE`.

Top module: `irq_target_sel`

## Requirements
- R1: When `redirect_en` is 1 at request time, `target` equals `self_cpu`, `err` is 0, and the round-robin pointer does not move.
- R2: When the processor `self_cpu` is offline (its bit in `online_mask` is 0) but some processor is online, `target` equals `self_cpu` with `err` 0.
- R3: When `online_mask` is all zero, `target` equals `self_cpu` and `err` is 1 in the `done` cycle; `err` is 0 whenever `done` is 0.
- R4: When `node_valid` is 1 and `node_mask & online_mask` has C>0 bits set, `target` is the set bit at position (`vector` mod C), counting from 0 at the lowest index.
- R5: When `node_valid` is 0, or the node mask has no online processor, the round-robin path is used whatever `node_mask` holds.
- R6: On the round-robin path the pointer is incremented, wraps from NCPU-1 to 0 (not at a power of two), and keeps advancing past offline processors until it lands on an online one, which is the target.
- R7: After reset the pointer sits before CPU 0, so the first round-robin selection examines CPU 0 first.
- R8: The pointer keeps its value between requests; fast-path and node-local selections leave it unchanged.
- R9: `done` is a one-cycle pulse that follows an accepted `req` within VEC_W+NCPU+3 cycles; `req` is ignored while a request is in progress.
- R10: `target` is always below NCPU when `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a selection (sampled in idle only) |
| online_mask | input | NCPU | One bit per processor, 1 = online |
| node_mask | input | NCPU | Processors local to the interrupt's node |
| node_valid | input | 1 | 1 when `node_mask` is meaningful |
| vector | input | VEC_W | Interrupt vector number |
| redirect_en | input | 1 | Platform redirection enabled: pick requester |
| self_cpu | input | IDX_W | Index of the requesting processor |
| done | output | 1 | One-cycle result strobe |
| target | output | IDX_W | Chosen processor index, valid with `done` |
| err | output | 1 | No processor online, valid with `done` |

## Verification
The bench builds the block with NCPU=6 and VEC_W=6. Six processors put the round-robin wrap at a count that is not a power of two, so an off-by-one at the wrap or a wrap at 8 becomes visible. A 6-bit vector keeps the divide phase short, yet vectors up to 63 still reach remainders at every position of a three-processor node. The bench also times each request against the latency bound. It sends a second request pulse during a long node-path request to show that the pulse is dropped.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_NODE_SCAN,
        ST_ROUND,
        ST_FIN
    } tsel_state_e;

endpackage

// File: rtl/tsel_popcnt.sv
module tsel_popcnt #(
    parameter int N     = 8,
    parameter int CNT_W = 4
) (
    input  logic [N-1:0]     mask,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end
endmodule

// File: rtl/tsel_modulo.sv
module tsel_modulo #(
    parameter int VEC_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] dividend,
    input  logic [CNT_W-1:0] divisor,
    output logic             valid,
    output logic [CNT_W-1:0] rem
);
    localparam int ST_W = $clog2(VEC_W + 1);

    logic [VEC_W-1:0] dvd_q;
    logic [CNT_W-1:0] dsr_q;
    logic [CNT_W-1:0] rem_q;
    logic [ST_W-1:0]  left_q;
    logic             valid_q;
    logic [CNT_W:0]   shifted;
    logic [CNT_W:0]   diff;
    logic             take;

    assign shifted = {rem_q, dvd_q[VEC_W-1]};
    assign diff    = shifted - {1'b0, dsr_q};
    assign take    = shifted >= {1'b0, dsr_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            dsr_q   <= '0;
            rem_q   <= '0;
            left_q  <= '0;
            valid_q <= 1'b0;
        end else if (start) begin
            dvd_q   <= dividend;
            dsr_q   <= divisor;
            rem_q   <= '0;
            left_q  <= ST_W'(VEC_W);
            valid_q <= 1'b0;
        end else if (left_q != '0) begin
            rem_q   <= take ? diff[CNT_W-1:0] : shifted[CNT_W-1:0];
            dvd_q   <= dvd_q << 1;
            left_q  <= left_q - ST_W'(1);
            valid_q <= (left_q == ST_W'(1));
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign rem   = rem_q;
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
    import tsel_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [NCPU-1:0]  online_mask,
    input  logic [NCPU-1:0]  node_mask,
    input  logic             node_valid,
    input  logic [VEC_W-1:0] vector,
    input  logic             redirect_en,
    input  logic [IDX_W-1:0] self_cpu,
    output logic             done,
    output logic [IDX_W-1:0] target,
    output logic             err
);
    localparam int CNT_W = $clog2(NCPU + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCPU - 1);

    tsel_state_e state_q, state_d;

    logic [NCPU-1:0]  on_q;
    logic [NCPU-1:0]  eff_q;
    logic [IDX_W-1:0] ptr_q;
    logic             ptr_vld_q;
    logic [IDX_W-1:0] scan_q;
    logic [CNT_W-1:0] k_q;
    logic [IDX_W-1:0] target_q;
    logic             err_q;

    logic [NCPU-1:0]  eff_in;
    logic [CNT_W-1:0] eff_cnt;
    logic             self_on;
    logic             fast_path;
    logic             mod_start;
    logic             mod_valid;
    logic [CNT_W-1:0] mod_rem;
    logic [IDX_W-1:0] rr_next;
    logic             scan_hit;

    assign eff_in    = node_valid ? (node_mask & online_mask) : '0;
    assign self_on   = (self_cpu <= LAST_IDX) && online_mask[self_cpu];
    assign fast_path = redirect_en || !self_on || (online_mask == '0);
    assign mod_start = (state_q == ST_IDLE) && req && !fast_path && (eff_in != '0);
    assign rr_next   = (!ptr_vld_q || ptr_q == LAST_IDX) ? '0 : ptr_q + IDX_W'(1);
    assign scan_hit  = eff_q[scan_q] && (k_q == '0);

    tsel_popcnt #(.N(NCPU), .CNT_W(CNT_W)) u_popcnt (
        .mask  (eff_in),
        .count (eff_cnt)
    );

    tsel_modulo #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_modulo (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mod_start),
        .dividend (vector),
        .divisor  (eff_cnt),
        .valid    (mod_valid),
        .rem      (mod_rem)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (fast_path)            state_d = ST_FIN;
                    else if (eff_in != '0)    state_d = ST_DIVIDE;
                    else                      state_d = ST_ROUND;
                end
            end
            ST_DIVIDE:    if (mod_valid)          state_d = ST_NODE_SCAN;
            ST_NODE_SCAN: if (scan_hit)           state_d = ST_FIN;
            ST_ROUND:     if (on_q[rr_next])      state_d = ST_FIN;
            ST_FIN:                               state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q      <= '0;
            eff_q     <= '0;
            ptr_q     <= '0;
            ptr_vld_q <= 1'b0;
            scan_q    <= '0;
            k_q       <= '0;
            target_q  <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        on_q     <= online_mask;
                        eff_q    <= eff_in;
                        scan_q   <= '0;
                        target_q <= self_cpu;
                        err_q    <= (online_mask == '0);
                    end
                end
                ST_DIVIDE: begin
                    if (mod_valid) k_q <= mod_rem;
                end
                ST_NODE_SCAN: begin
                    if (eff_q[scan_q]) begin
                        if (k_q == '0) target_q <= scan_q;
                        else           k_q <= k_q - CNT_W'(1);
                    end
                    scan_q <= scan_q + IDX_W'(1);
                end
                ST_ROUND: begin
                    ptr_q     <= rr_next;
                    ptr_vld_q <= 1'b1;
                    if (on_q[rr_next]) target_q <= rr_next;
                end
                ST_FIN: begin
                    err_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign done   = (state_q == ST_FIN);
    assign target = target_q;
    assign err    = err_q && (state_q == ST_FIN);
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
    parameter int NCPU  = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [NCPU-1:0]  online_mask,
    input logic             redirect_en,
    input logic [IDX_W-1:0] self_cpu,
    input logic             done,
    input logic [IDX_W-1:0] target,
    input logic             err
);
    localparam int LIMIT = VEC_W + NCPU + 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCPU - 1);

    logic             busy_c;
    logic [15:0]      age_c;
    logic             redir_l;
    logic             empty_l;
    logic [IDX_W-1:0] self_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c  <= 1'b0;
            age_c   <= '0;
            redir_l <= 1'b0;
            empty_l <= 1'b0;
            self_l  <= '0;
        end else if (done) begin
            busy_c <= 1'b0;
            age_c  <= '0;
        end else if (req && !busy_c) begin
            busy_c  <= 1'b1;
            age_c   <= 16'd1;
            redir_l <= redirect_en;
            empty_l <= (online_mask == '0);
            self_l  <= self_cpu;
        end else if (busy_c) begin
            age_c <= age_c + 16'd1;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        age_c <= 16'(LIMIT));
    assert_done_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_c);
    assert_err_only_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    assert_empty_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_c && empty_l) |-> (err && target == self_l));
    assert_redirect_self_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_c && redir_l) |-> (target == self_l));
    assert_target_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (target <= LAST_IDX));
endmodule

bind irq_target_sel tsel_chk #(.NCPU(NCPU), .VEC_W(VEC_W)) u_tsel_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .online_mask (online_mask),
    .redirect_en (redirect_en),
    .self_cpu    (self_cpu),
    .done        (done),
    .target      (target),
    .err         (err)
);

// File: tb/test_irq_target_sel.sv
module test_irq_target_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU  = 6;
    localparam int VEC_W = 6;
    localparam int IDX_W = 3;
    localparam int LAT_MAX = VEC_W + NCPU + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [NCPU-1:0]  online_mask = '0;
    logic [NCPU-1:0]  node_mask = '0;
    logic             node_valid = 1'b0;
    logic [VEC_W-1:0] vector = '0;
    logic             redirect_en = 1'b0;
    logic [IDX_W-1:0] self_cpu = '0;
    logic             done;
    logic [IDX_W-1:0] target;
    logic             err;

    typedef struct {
        int    tgt;
        bit    err;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   m_ptr   = -1;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_target_sel #(.NCPU(NCPU), .VEC_W(VEC_W)) i_irq_target_sel (
        .clk (clk), .rst_n (rst_n), .req (req),
        .online_mask (online_mask), .node_mask (node_mask),
        .node_valid (node_valid), .vector (vector),
        .redirect_en (redirect_en), .self_cpu (self_cpu),
        .done (done), .target (target), .err (err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", int'(target), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(target) == e.tgt, e.tag, int'(target), e.tgt);
                check(err == e.err, {e.tag, " err"}, int'(err), int'(e.err));
                check(int'(target) < NCPU, "R10 target range", int'(target), NCPU - 1);
            end
        end
    end

    function automatic exp_t model(input bit rd, input int self, input bit [NCPU-1:0] on,
                                   input bit [NCPU-1:0] nd, input bit nv, input int vec,
                                   input string tag);
        exp_t e;
        bit [NCPU-1:0] eff;
        int cnt;
        int pos;
        e.tag = tag;
        e.err = 1'b0;
        eff = nv ? (nd & on) : '0;
        cnt = $countones(eff);
        if (on == '0) begin
            e.tgt = self; e.err = 1'b1;
        end else if (rd || !on[self]) begin
            e.tgt = self;
        end else if (cnt > 0) begin
            pos = vec % cnt;
            e.tgt = -1;
            for (int i = 0; i < NCPU; i++) begin
                if (eff[i]) begin
                    if (pos == 0 && e.tgt < 0) e.tgt = i;
                    pos--;
                end
            end
        end else begin
            do begin
                m_ptr = (m_ptr + 1 >= NCPU) ? 0 : m_ptr + 1;
            end while (!on[m_ptr]);
            e.tgt = m_ptr;
        end
        return e;
    endfunction

    task automatic run(input bit rd, input int self, input bit [NCPU-1:0] on,
                       input bit [NCPU-1:0] nd, input bit nv, input int vec,
                       input string tag, input bit extra_pulse);
        int lat;
        exp_q.push_back(model(rd, self, on, nd, nv, vec, tag));
        @(negedge clk);
        redirect_en = rd; self_cpu = IDX_W'(self); online_mask = on;
        node_mask = nd; node_valid = nv; vector = VEC_W'(vec);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        if (extra_pulse) begin
            @(negedge clk); lat++;
            req = 1'b1;
            @(negedge clk); lat++;
            req = 1'b0;
        end
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(lat <= LAT_MAX, {tag, " R9 latency"}, lat, LAT_MAX);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && err == 1'b0, "R9 reset state", int'(done), 0);
        rst_n = 1'b1;
        // R7: first round-robin pick examines CPU 0
        run(0, 2, 6'b111111, 6'b000000, 0, 0, "R7 first rr", 0);
        // R6: skip offline CPU 1
        run(0, 0, 6'b101101, 6'b000000, 0, 0, "R6 skip offline", 0);
        // R1: redirect picks requester, pointer untouched
        run(1, 4, 6'b111111, 6'b111111, 1, 7, "R1 redirect", 0);
        // R8: pointer continued from 2
        run(0, 0, 6'b101101, 6'b000000, 0, 0, "R8 persist", 0);
        run(0, 0, 6'b101101, 6'b000000, 0, 0, "R6 advance", 0);
        // R6: wrap at 6 back to 0
        run(0, 0, 6'b101101, 6'b000000, 0, 0, "R6 wrap", 0);
        // R2: requester offline
        run(0, 1, 6'b101101, 6'b000000, 0, 0, "R2 self offline", 0);
        // R3: no CPU online
        run(0, 3, 6'b000000, 6'b111111, 1, 5, "R3 empty online", 0);
        // R4: node-local selection, online node CPUs {1,3,5}
        run(0, 0, 6'b101011, 6'b111010, 1, 5,  "R4 vec5", 0);
        run(0, 0, 6'b101011, 6'b111010, 1, 0,  "R4 vec0", 0);
        run(0, 0, 6'b101011, 6'b111010, 1, 63, "R4 vec63", 0);
        run(0, 0, 6'b101011, 6'b111010, 1, 4,  "R4 vec4", 0);
        run(0, 0, 6'b101011, 6'b100000, 1, 4,  "R4 single", 0);
        // R5: node valid but no online node CPU
        run(0, 0, 6'b101011, 6'b010100, 1, 3, "R5 node offline", 0);
        // R5: node invalid, mask ignored
        run(0, 0, 6'b101011, 6'b111111, 0, 3, "R5 node invalid", 0);
        // R8: node selection left pointer unchanged
        run(0, 0, 6'b101011, 6'b000000, 0, 0, "R8 after node", 0);
        // R9: second req during busy is dropped
        run(0, 0, 6'b101011, 6'b111010, 1, 62, "R9 busy req", 1);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule